// File: doc/BRIEF.md
# I2C Master Serial Clock Waveform Generator

This block produces the serial clock for an I2C master. The clock has a low phase and a high phase, and each phase has its own 8-bit divider. A 3-bit exponent sets a power-of-two prescale factor that both phases share. Each phase lasts its divider times two raised to the exponent, plus four system clock cycles. Two equal dividers give a 50% duty cycle. Two different dividers give an asymmetric waveform, for example to meet separate minimum low and high times.

While the enable input is low, the clock rests high and every internal counter holds zero. When enable is raised, the block drives the clock low one cycle later and then alternates between the phases without stopping. It fires a one-cycle strobe in the first cycle of every low phase and another in the first cycle of every high phase. A byte engine placed next to the block uses these strobes to change SDA or to sample it. The dividers and the exponent are captured only when a phase begins. Software can therefore reprogram them at any time, and the phase already running is never shortened.

Top module: `scl_wavegen`

## Requirements
- R1: One rising clock edge with `rst_n` low leaves `scl_o` at 1 and both strobes at 0 in the following cycle. When `rst_n` is released with `enable` high, a fresh low phase begins with a falling strobe.
- R2: While `enable` is sampled 0, `scl_o` is 1 and neither strobe fires. Dropping `enable` in the middle of a phase sets `scl_o` to 1 one cycle later, with no rising strobe.
- R3: The first clock edge that samples `enable` at 1 after rest sets `scl_o` to 0 and `fall_stb` to 1 in the next cycle.
- R4: A low phase lasts exactly `lo_div * 2**pre_exp + 4` cycles of `clk`.
- R5: A high phase lasts exactly `hi_div * 2**pre_exp + 4` cycles, set independently of the low divider.
- R6: When the dividers are 0, each phase lasts exactly 4 cycles, whatever the exponent.
- R7: `fall_stb` is 1 only in the first cycle of a low phase, and `rise_stb` is 1 only in the first cycle of a high phase that follows a low phase. The two strobes are never 1 together, and each lasts one cycle.
- R8: The dividers and the exponent are sampled only on the clock edge that begins a phase. A change in the middle of a phase first takes effect in the next phase of the kind it governs.
- R9: After a disable in the middle of a phase, re-enabling starts a full low phase. No count is left over from the phase that was cut off.
- R10: The longest setting (`lo_div` = 255, `pre_exp` = 7) gives a low phase of 32644 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run the waveform; low returns the clock to rest |
| lo_div | input | 8 | Low-phase divider |
| hi_div | input | 8 | High-phase divider |
| pre_exp | input | 3 | Prescale exponent shared by both phases |
| scl_o | output | 1 | Serial clock drive level, 1 = released high |
| fall_stb | output | 1 | One-cycle strobe in the first low cycle |
| rise_stb | output | 1 | One-cycle strobe in the first high cycle |

## Verification
Two things can happen on the same edge: a phase expires, and new divider values arrive or `enable` drops. In the first collision, the bench rewrites the dividers and the exponent partway through a low phase. The full low length must keep its old value. The following high and low phases must then use the new values. In the second collision, a disable or a reset is applied partway through a low phase. The clock must return high with no rising strobe, and the next enable must give a complete low phase.

// File: rtl/scl_wave_pkg.sv
// Package: shared phase encoding and default sizes for the SCL waveform generator.
// Assumes: included in compile order before every module that uses it.
package scl_wave_pkg;

    // Phase of the generated clock; IDLE is the released, resting state.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    // Default widths and the fixed per-phase offset.
    localparam int DEF_DIV_W  = 8;
    localparam int DEF_EXP_W  = 3;
    localparam int DEF_OFFSET = 4;

endpackage

// File: rtl/scl_prescale_timer.sv
// Module: scl_prescale_timer
// Counts out one phase of div * 2**exp + OFFSET cycles. The counting runs in
// three stages: a prescaler that wraps every 2**exp cycles, a tick counter
// that holds the remaining divider ticks, and a final offset countdown.
// Assumes: load and clear are exclusive in practice (clear wins), OFFSET >= 2,
// and load is pulsed on the edge that begins a phase. last_o is high during
// the final cycle of the loaded phase.
module scl_prescale_timer #(
    parameter int DIV_W  = 8,
    parameter int EXP_W  = 3,
    parameter int OFFSET = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic [EXP_W-1:0] exp_in,
    output logic             last_o
);

    // Largest prescale reload is 2**(2**EXP_W - 1) - 1, which needs PRE_W bits.
    localparam int PRE_W = (1 << EXP_W) - 1;
    localparam int OFF_W = $clog2(OFFSET);

    logic [DIV_W-1:0] tick_q;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] reload_q;
    logic [OFF_W-1:0] off_q;

    logic [PRE_W:0]   pre_one;
    logic [PRE_W-1:0] pre_load;

    // Prescale reload value: 2**exp - 1.
    always_comb begin
        pre_one  = (PRE_W+1)'(1) << exp_in;
        pre_load = PRE_W'(pre_one - (PRE_W+1)'(1));
    end

    // Load on phase entry, clear at rest, otherwise step the three stages in order.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            tick_q   <= '0;
            pre_q    <= '0;
            reload_q <= '0;
            off_q    <= '0;
        end else if (load) begin
            tick_q   <= div_in;
            pre_q    <= pre_load;
            reload_q <= pre_load;
            off_q    <= OFF_W'(OFFSET - 1);
        end else if (tick_q != '0) begin
            if (pre_q == '0) begin
                tick_q <= tick_q - DIV_W'(1);
                pre_q  <= reload_q;
            end else begin
                pre_q <= pre_q - PRE_W'(1);
            end
        end else if (off_q != '0) begin
            off_q <= off_q - OFF_W'(1);
        end
    end

    // Final cycle of the phase: every divider tick used and the offset run down.
    always_comb begin
        last_o = (tick_q == '0) && (off_q == '0);
    end

endmodule

// File: rtl/scl_phase_fsm.sv
// Module: scl_phase_fsm
// Sequences the clock through rest, low and high. It requests a timer load at
// every phase entry, picks which divider the timer takes, and registers the
// clock level and the two boundary strobes.
// Assumes: last_i comes from a timer that was loaded on the most recent entry.
// Dropping enable returns to rest at once and fires no strobe.
module scl_phase_fsm
    import scl_wave_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic last_i,
    output logic load_o,
    output logic sel_hi_o,
    output logic clear_o,
    output logic scl_o,
    output logic fall_stb,
    output logic rise_stb
);

    scl_phase_e phase_q;
    scl_phase_e phase_d;
    logic       fall_d;
    logic       rise_d;

    // Next phase and boundary events for this cycle.
    always_comb begin
        phase_d = phase_q;
        fall_d  = 1'b0;
        rise_d  = 1'b0;
        if (!enable) begin
            phase_d = PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    phase_d = PH_LOW;
                    fall_d  = 1'b1;
                end
                PH_LOW: begin
                    if (last_i) begin
                        phase_d = PH_HIGH;
                        rise_d  = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (last_i) begin
                        phase_d = PH_LOW;
                        fall_d  = 1'b1;
                    end
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Timer controls: load on any phase entry, high divider when leaving low.
    always_comb begin
        load_o   = fall_d || rise_d;
        sel_hi_o = (phase_q == PH_LOW);
        clear_o  = !enable;
    end

    // Phase register with registered clock level and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            scl_o    <= 1'b1;
            fall_stb <= 1'b0;
            rise_stb <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            scl_o    <= (phase_d != PH_LOW);
            fall_stb <= fall_d;
            rise_stb <= rise_d;
        end
    end

endmodule

// File: rtl/scl_wavegen.sv
// Module: scl_wavegen (top)
// I2C master serial clock generator with separate low and high dividers and a
// shared power-of-two prescaler. It joins the phase sequencer to one timer and
// selects which divider the timer takes on each phase entry.
// Assumes: a single clock domain, synchronous active-low reset, and divider
// inputs that are quasi-static (they are used only when a phase begins).
module scl_wavegen
    import scl_wave_pkg::*;
#(
    parameter int DIV_W  = DEF_DIV_W,
    parameter int EXP_W  = DEF_EXP_W,
    parameter int OFFSET = DEF_OFFSET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] lo_div,
    input  logic [DIV_W-1:0] hi_div,
    input  logic [EXP_W-1:0] pre_exp,
    output logic             scl_o,
    output logic             fall_stb,
    output logic             rise_stb
);

    logic             tmr_last;
    logic             tmr_load;
    logic             tmr_clear;
    logic             sel_hi;
    logic [DIV_W-1:0] div_sel;

    // Divider chosen for the phase being entered.
    always_comb begin
        div_sel = sel_hi ? hi_div : lo_div;
    end

    scl_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .last_i   (tmr_last),
        .load_o   (tmr_load),
        .sel_hi_o (sel_hi),
        .clear_o  (tmr_clear),
        .scl_o    (scl_o),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb)
    );

    scl_prescale_timer #(
        .DIV_W  (DIV_W),
        .EXP_W  (EXP_W),
        .OFFSET (OFFSET)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .load   (tmr_load),
        .div_in (div_sel),
        .exp_in (pre_exp),
        .last_o (tmr_last)
    );

endmodule

// File: rtl/scl_wavegen_chk.sv
// Module: scl_wavegen_chk
// Property checker bound to scl_wavegen. It watches only the ports. Phase
// lengths are checked with run counters against lengths latched from the
// inputs on the edge that began each phase.
module scl_wavegen_chk #(
    parameter int DIV_W  = 8,
    parameter int EXP_W  = 3,
    parameter int OFFSET = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [DIV_W-1:0] lo_div,
    input logic [DIV_W-1:0] hi_div,
    input logic [EXP_W-1:0] pre_exp,
    input logic             scl_o,
    input logic             fall_stb,
    input logic             rise_stb
);

    logic [31:0] prev_lo;
    logic [31:0] prev_hi;
    logic [31:0] want_lo;
    logic [31:0] want_hi;
    logic [31:0] low_cnt;
    logic [31:0] high_cnt;
    logic        hi_ok;

    // Track requested lengths, latch them at phase entry, and count run lengths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lo  <= '0;
            prev_hi  <= '0;
            want_lo  <= '0;
            want_hi  <= '0;
            low_cnt  <= '0;
            high_cnt <= '0;
            hi_ok    <= 1'b0;
        end else begin
            prev_lo <= (32'(lo_div) << pre_exp) + 32'(OFFSET);
            prev_hi <= (32'(hi_div) << pre_exp) + 32'(OFFSET);
            if (fall_stb) begin
                want_lo <= prev_lo;
                low_cnt <= 32'd1;
            end else if (!scl_o) begin
                low_cnt <= low_cnt + 32'd1;
            end
            if (rise_stb) begin
                want_hi  <= prev_hi;
                high_cnt <= 32'd1;
            end else if (scl_o && high_cnt != 32'hFFFF_FFFF) begin
                high_cnt <= high_cnt + 32'd1;
            end
            if (!enable) begin
                hi_ok <= 1'b0;
            end else if (rise_stb) begin
                hi_ok <= 1'b1;
            end
        end
    end

    assert_reset_rest_R1: assert property (@(posedge clk)
        !rst_n |=> (scl_o && !fall_stb && !rise_stb));

    assert_idle_rest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_o && !fall_stb && !rise_stb));

    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> (fall_stb && !scl_o));

    assert_low_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (low_cnt == want_lo));

    assert_high_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_stb && hi_ok) |-> (high_cnt == want_hi));

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_stb && rise_stb));

    assert_fall_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (!scl_o && $past(scl_o)));

    assert_rise_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (scl_o && !$past(scl_o)));

    assert_fall_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb);

    assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_o) |-> (rise_stb || !$past(enable)));

endmodule

bind scl_wavegen scl_wavegen_chk #(
    .DIV_W  (DIV_W),
    .EXP_W  (EXP_W),
    .OFFSET (OFFSET)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .lo_div   (lo_div),
    .hi_div   (hi_div),
    .pre_exp  (pre_exp),
    .scl_o    (scl_o),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb)
);

// File: tb/scl_wavegen_test.sv
// Bench for scl_wavegen. A vector table is walked first, followed by directed
// tests for mid-phase reprogramming, disable, reset and the longest phase.
module scl_wavegen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] lo_div = 8'd0;
    logic [7:0] hi_div = 8'd0;
    logic [2:0] pre_exp = 3'd0;
    logic       scl_o;
    logic       fall_stb;
    logic       rise_stb;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scl_wavegen uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .lo_div   (lo_div),
        .hi_div   (hi_div),
        .pre_exp  (pre_exp),
        .scl_o    (scl_o),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb)
    );

    typedef struct packed {
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [2:0]  ex;
        logic [15:0] lo_len;
        logic [15:0] hi_len;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'd0,   8'd0, 3'd0, 16'd4,   16'd4},
        '{8'd1,   8'd1, 3'd0, 16'd5,   16'd5},
        '{8'd3,   8'd7, 3'd1, 16'd10,  16'd18},
        '{8'd10,  8'd2, 3'd2, 16'd44,  16'd12},
        '{8'd5,   8'd5, 3'd3, 16'd44,  16'd44},
        '{8'd255, 8'd0, 3'd0, 16'd259, 16'd4},
        '{8'd2,   8'd1, 3'd7, 16'd260, 16'd132},
        '{8'd0,   8'd1, 3'd5, 16'd4,   16'd36}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts low cycles starting from the current negedge (the first low cycle).
    task automatic run_low(output int n);
        n = 0;
        while (scl_o == 1'b0 && n < 40000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Counts high cycles starting from the current negedge (the first high cycle).
    task automatic run_high(output int n);
        n = 0;
        while (scl_o == 1'b1 && n < 40000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Raises enable from rest and checks the first low cycle.
    task automatic start_run(input string req);
        enable = 1'b1;
        @(negedge clk);
        chk(fall_stb == 1'b1 && scl_o == 1'b0, req, {30'd0, fall_stb, scl_o}, 2);
    endtask

    task automatic go_idle();
        enable = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int n;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(scl_o == 1'b1, "R1 scl in reset", scl_o, 1);
        chk(fall_stb == 1'b0 && rise_stb == 1'b0, "R1 strobes in reset",
            {fall_stb, rise_stb}, 0);
        rst_n = 1'b1;

        // R2: idle with changing dividers
        for (int i = 0; i < 6; i++) begin
            lo_div = 8'(i * 37);
            hi_div = 8'(i * 11);
            @(negedge clk);
            chk(scl_o == 1'b1 && !fall_stb && !rise_stb, "R2 idle rest",
                {scl_o, fall_stb, rise_stb}, 4);
        end

        // Vector table: R3 start, R4/R5 lengths, R6 zero dividers, R7 strobes
        for (int v = 0; v < NVEC; v++) begin
            go_idle();
            lo_div  = VECS[v].lo;
            hi_div  = VECS[v].hi;
            pre_exp = VECS[v].ex;
            start_run("R3 first fall");
            @(negedge clk);
            chk(fall_stb == 1'b0, "R7 fall strobe one cycle", fall_stb, 0);
            run_low(n);
            n = n + 1;
            chk(n == int'(VECS[v].lo_len), (v == 0) ? "R6 low zero div" : "R4 low length",
                n, int'(VECS[v].lo_len));
            chk(rise_stb == 1'b1 && fall_stb == 1'b0, "R7 rise strobe",
                {rise_stb, fall_stb}, 2);
            run_high(n);
            chk(n == int'(VECS[v].hi_len), (v == 0) ? "R6 high zero div" : "R5 high length",
                n, int'(VECS[v].hi_len));
            chk(fall_stb == 1'b1, "R7 fall strobe repeat", fall_stb, 1);
            run_low(n);
            chk(n == int'(VECS[v].lo_len), "R4 steady low length", n, int'(VECS[v].lo_len));
        end

        // R8: reprogram in the middle of a low phase
        go_idle();
        lo_div = 8'd20; hi_div = 8'd2; pre_exp = 3'd0;
        start_run("R3 start before R8");
        n = 0;
        repeat (5) begin n++; @(negedge clk); end
        lo_div = 8'd0; hi_div = 8'd5; pre_exp = 3'd1;
        begin
            int m;
            run_low(m);
            n = n + m;
        end
        chk(n == 24, "R8 running low kept", n, 24);
        run_high(n);
        chk(n == 14, "R8 next high uses new values", n, 14);
        run_low(n);
        chk(n == 4, "R8 next low uses new values", n, 4);

        // R2/R9: disable mid-low, then re-enable
        go_idle();
        lo_div = 8'd30; hi_div = 8'd1; pre_exp = 3'd0;
        start_run("R3 start before R9");
        repeat (10) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(scl_o == 1'b1 && rise_stb == 1'b0, "R2 abort rises without strobe",
            {scl_o, rise_stb}, 2);
        repeat (2) @(negedge clk);
        start_run("R9 restart fall");
        run_low(n);
        chk(n == 34, "R9 full low after restart", n, 34);

        // R1: reset mid-run, then release with enable high
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(scl_o == 1'b1 && !fall_stb && !rise_stb, "R1 reset mid-run",
            {scl_o, fall_stb, rise_stb}, 4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fall_stb == 1'b1 && scl_o == 1'b0, "R1 fresh low after reset",
            {fall_stb, scl_o}, 2);

        // R10: longest low phase
        go_idle();
        lo_div = 8'd255; hi_div = 8'd0; pre_exp = 3'd7;
        start_run("R3 start before R10");
        run_low(n);
        chk(n == 32644, "R10 longest low", n, 32644);
        run_high(n);
        chk(n == 4, "R6 zero high with max exponent", n, 4);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule